// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a 16-bit up-counting timer with one output compare channel and the logic that drives a compare-output pin. The counter advances on each cycle where the timer clock enable is high. It can run freely with a wrap from all-ones to zero, or it can clear itself after reaching a programmable TOP value. A bus-side write port loads the counter directly. A write also suppresses every compare event, the TOP event included, for the next timer tick.

When the counter equals the compare value on an unblocked tick, the channel reports a one-cycle match flag. It then updates its output-compare state bit according to a two-bit action mode, which is applied with no buffering. A force strobe applies the same action at any time, but it does not raise the flag and does not touch the counter.

The pin value comes from the compare state whenever the mode is non-zero, and from the general port bit otherwise. Pin direction always follows the data direction bit, and an input direction is shown as a deasserted output enable.

Top module: `tmr_ocu_top`

## Requirements
- R1: With `clr_on_top` low, the counter rises by one on every cycle with `tick` high, wraps from 0xFFFF to 0x0000, and holds its value when `tick` is low.
- R2: A cycle with `cnt_wr_en` high loads `cnt_wr_data` into the counter, and the new value is visible on `cnt_q` one cycle later. The write wins over a tick in the same cycle.
- R3: On an unblocked tick where `cnt_q` equals `cmp_val`, `match_flag` is high for exactly the following cycle, and `oc_state` is updated in that same cycle.
- R4: The action taken on a match or a force depends on `out_mode`: 2'b00 leaves `oc_state` unchanged, 2'b01 inverts it, 2'b10 drives it to 0, and 2'b11 drives it to 1.
- R5: After a counter write, the next tick evaluates no compare and no TOP event. The counter still advances by one on that tick. If the written value equals `cmp_val`, that match is lost, so `match_flag` stays low and `oc_state` stays the same.
- R6: With `clr_on_top` high, an unblocked tick at `cnt_q == top_val` loads 0. If the counter was written to TOP, the TOP event is skipped, and the count continues upward through 0xFFFF and wraps to 0.
- R7: A one-cycle `force_cmp` pulse applies the R4 action to `oc_state` one cycle later. It leaves `match_flag` low and the counter unchanged.
- R8: `oc_state` is 0 after reset, and it keeps its value when `clr_on_top` or `out_mode` changes.
- R9: `pin_out` equals `oc_state` whenever `out_mode` is non-zero, and equals `port_bit` when `out_mode` is 2'b00. A change of mode reaches the pin without waiting for a clock edge.
- R10: `pin_oe` follows `ddr_bit` at all times (1 = output, 0 = high impedance).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| cnt_wr_en | input | 1 | Bus write strobe for the counter |
| cnt_wr_data | input | 16 | Value written to the counter |
| cmp_val | input | 16 | Compare value |
| top_val | input | 16 | TOP value for clear-on-TOP counting |
| clr_on_top | input | 1 | 1 = clear on TOP, 0 = free-running |
| out_mode | input | 2 | Compare action and pin source select |
| force_cmp | input | 1 | Force-compare strobe |
| port_bit | input | 1 | General port output value |
| ddr_bit | input | 1 | Data direction (1 = output) |
| cnt_q | output | 16 | Current counter value |
| oc_state | output | 1 | Output-compare state bit |
| match_flag | output | 1 | One-cycle compare-match pulse |
| pin_out | output | 1 | Value driven on the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
A counter write, a tick, a match or a force each produces its result one clock later: the new value appears on `cnt_q`, `match_flag` or `oc_state` in the cycle after the edge that captured the stimulus. The pin mux and output enable react within the same cycle. Inputs are changed shortly after a rising edge, and every registered result is sampled after exactly one further edge. Pin results are sampled with no edge in between. Blocked-match cases step through the write, the blocked tick and the following tick one at a time, so a match that arrives a tick late is caught.

// File: rtl/tmr_ocu_pkg.sv
// Package: shared types and the compare-action function for the timer
// output compare channel. Assumes a two-bit action code.
package tmr_ocu_pkg;
    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_CLEAR  = 2'b10,
        OM_SET    = 2'b11
    } oc_mode_e;

    // Next compare state for a given action code and current state.
    function automatic logic oc_apply(input logic [1:0] mode, input logic cur);
        case (oc_mode_e'(mode))
            OM_TOGGLE: oc_apply = ~cur;
            OM_CLEAR:  oc_apply = 1'b0;
            OM_SET:    oc_apply = 1'b1;
            default:   oc_apply = cur;
        endcase
    endfunction
endpackage

// File: rtl/tmr_counter.sv
// Module: up counter with bus load, optional clear on TOP, and a one-tick
// compare block after every load. Assumes tick is a single-cycle enable.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] top_val,
    input  logic             clr_on_top,
    output logic [CNT_W-1:0] cnt,
    output logic             cmp_gate
);
    logic blk;
    logic top_hit;

    // Compare events are allowed only on an unblocked tick with no write.
    always_comb cmp_gate = tick && !wr_en && !blk;

    // TOP event for clear-on-TOP counting.
    always_comb top_hit = cmp_gate && clr_on_top && (cnt == top_val);

    // Counter register: a load wins over a tick; TOP clears, otherwise increment.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (wr_en)      cnt <= wr_data;
        else if (top_hit)    cnt <= '0;
        else if (tick)       cnt <= cnt + 1'b1;
    end

    // Block flag: raised by a load, released by the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        blk <= 1'b0;
        else if (wr_en)    blk <= 1'b1;
        else if (tick)     blk <= 1'b0;
    end
endmodule

// File: rtl/tmr_cmp_wave.sv
// Module: compare detector and output-compare state register. Assumes
// cmp_gate already excludes blocked ticks and write cycles.
module tmr_cmp_wave #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_gate,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [1:0]       mode,
    input  logic             force_cmp,
    output logic             oc,
    output logic             flag
);
    import tmr_ocu_pkg::*;

    logic hit;

    // Match event on an allowed tick.
    always_comb hit = cmp_gate && (cnt == cmp_val);

    // State register: a match or a force applies the current action code.
    always_ff @(posedge clk) begin
        if (!rst_n)                oc <= 1'b0;
        else if (hit || force_cmp) oc <= oc_apply(mode, oc);
    end

    // Flag register: one-cycle pulse after each real match.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= hit;
    end
endmodule

// File: rtl/tmr_pin_mux.sv
// Module: pin source select and direction. Purely combinational so that
// action-code changes reach the pin at once.
module tmr_pin_mux (
    input  logic       oc,
    input  logic [1:0] mode,
    input  logic       port_bit,
    input  logic       ddr_bit,
    output logic       pin_out,
    output logic       pin_oe
);
    // Compare state overrides the port bit whenever any mode bit is set.
    always_comb pin_out = (|mode) ? oc : port_bit;

    // Direction always from the data direction bit.
    always_comb pin_oe = ddr_bit;
endmodule

// File: rtl/tmr_ocu_top.sv
// Module: timer output compare channel top. Ties the counter, the compare
// unit and the pin mux together. Assumes all inputs are synchronous to clk.
module tmr_ocu_top #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [CNT_W-1:0] top_val,
    input  logic             clr_on_top,
    input  logic [1:0]       out_mode,
    input  logic             force_cmp,
    input  logic             port_bit,
    input  logic             ddr_bit,
    output logic [CNT_W-1:0] cnt_q,
    output logic             oc_state,
    output logic             match_flag,
    output logic             pin_out,
    output logic             pin_oe
);
    logic cmp_gate;

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(cnt_wr_en),
        .wr_data(cnt_wr_data), .top_val(top_val), .clr_on_top(clr_on_top),
        .cnt(cnt_q), .cmp_gate(cmp_gate)
    );

    tmr_cmp_wave #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cmp_gate(cmp_gate), .cnt(cnt_q),
        .cmp_val(cmp_val), .mode(out_mode), .force_cmp(force_cmp),
        .oc(oc_state), .flag(match_flag)
    );

    tmr_pin_mux u_pin (
        .oc(oc_state), .mode(out_mode), .port_bit(port_bit), .ddr_bit(ddr_bit),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );
endmodule

// File: rtl/tmr_ocu_chk.sv
// Module: assertion checker for tmr_ocu_top, attached by bind below.
module tmr_ocu_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cnt_wr_en,
    input logic [CNT_W-1:0] cnt_wr_data,
    input logic [CNT_W-1:0] cmp_val,
    input logic [CNT_W-1:0] top_val,
    input logic             clr_on_top,
    input logic [1:0]       out_mode,
    input logic             force_cmp,
    input logic             port_bit,
    input logic             ddr_bit,
    input logic [CNT_W-1:0] cnt_q,
    input logic             oc_state,
    input logic             match_flag,
    input logic             pin_out,
    input logic             pin_oe
);
    a_r1_free_count: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr_en && !clr_on_top) |=> cnt_q == $past(cnt_q) + 1'b1);

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> cnt_q == $past(cnt_wr_data));

    a_r5_write_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> !match_flag);

    a_r3_flag_on_equal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(cnt_q == cmp_val) && $past(tick));

    a_r6_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_on_top && tick && !cnt_wr_en && cnt_q != top_val && cnt_q != {CNT_W{1'b1}})
        |=> cnt_q == $past(cnt_q) + 1'b1);

    a_r8_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_flag && !$past(force_cmp)) |-> $stable(oc_state));

    a_r7_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cmp && !tick) |=> !match_flag);

    a_r9_pin_source: assert property (@(posedge clk) disable iff (!rst_n)
        pin_out == ((out_mode != 2'b00) ? oc_state : port_bit));

    a_r10_pin_dir: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe == ddr_bit);
endmodule

bind tmr_ocu_top tmr_ocu_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_tmr_ocu_top.sv
module tb_tmr_ocu_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick, cnt_wr_en, clr_on_top, force_cmp, port_bit, ddr_bit;
    logic [15:0] cnt_wr_data, cmp_val, top_val;
    logic [1:0]  out_mode;
    logic [15:0] cnt_q;
    logic        oc_state, match_flag, pin_out, pin_oe;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    tmr_ocu_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr_en(cnt_wr_en),
        .cnt_wr_data(cnt_wr_data), .cmp_val(cmp_val), .top_val(top_val),
        .clr_on_top(clr_on_top), .out_mode(out_mode), .force_cmp(force_cmp),
        .port_bit(port_bit), .ddr_bit(ddr_bit), .cnt_q(cnt_q), .oc_state(oc_state),
        .match_flag(match_flag), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock edge; returns 1 ns after it.
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        cnt_wr_en = 1'b1; cnt_wr_data = v;
        cyc();
        cnt_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8 reset cnt", cnt_q, 16'h0);
        chk("R8 reset oc", {15'b0, oc_state}, 16'h0);
        chk("R3 reset flag", {15'b0, match_flag}, 16'h0);
    endtask

    task automatic t_count();
        tick = 1'b1;
        for (int i = 0; i < 5; i++) cyc();
        chk("R1 count 5", cnt_q, 16'd5);
        tick = 1'b0;
        cyc(); cyc();
        chk("R1 hold", cnt_q, 16'd5);
        tick = 1'b1;
        wr_cnt(16'hFFFE);
        chk("R2 load over tick", cnt_q, 16'hFFFE);
        cyc();
        chk("R1 to FFFF", cnt_q, 16'hFFFF);
        cyc();
        chk("R1 wrap", cnt_q, 16'h0000);
    endtask

    task automatic t_match();
        logic [1:0] modes [5] = '{2'b01, 2'b10, 2'b11, 2'b01, 2'b00};
        logic       exp_oc [5] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
        cmp_val = 16'd10;
        tick = 1'b1;
        for (int k = 0; k < 5; k++) begin
            out_mode = modes[k];
            wr_cnt(16'd9);
            cyc();
            chk("R5 blocked tick advances", cnt_q, 16'd10);
            chk("R5 no flag on blocked", {15'b0, match_flag}, 16'h0);
            cyc();
            chk("R3 flag", {15'b0, match_flag}, 16'h1);
            chk("R4 action", {15'b0, oc_state}, {15'b0, exp_oc[k]});
            cyc();
            chk("R3 flag one cycle", {15'b0, match_flag}, 16'h0);
        end
    endtask

    task automatic t_block();
        cmp_val = 16'd20;
        out_mode = 2'b01;
        tick = 1'b1;
        wr_cnt(16'd20);
        cyc();
        chk("R5 lost match cnt", cnt_q, 16'd21);
        chk("R5 lost match flag", {15'b0, match_flag}, 16'h0);
        chk("R5 lost match oc", {15'b0, oc_state}, 16'h0);
        tick = 1'b0;
        wr_cnt(16'd20);
        cyc(); cyc();
        tick = 1'b1;
        cyc();
        chk("R5 block held until tick", {15'b0, match_flag}, 16'h0);
        chk("R5 idle-timer block oc", {15'b0, oc_state}, 16'h0);
    endtask

    task automatic t_top();
        cmp_val = 16'd1000;
        top_val = 16'd30;
        clr_on_top = 1'b1;
        tick = 1'b1;
        wr_cnt(16'd28);
        cyc(); cyc();
        chk("R6 at top", cnt_q, 16'd30);
        cyc();
        chk("R6 clear", cnt_q, 16'd0);
        wr_cnt(16'd30);
        cyc();
        chk("R6 top skipped", cnt_q, 16'd31);
        cyc();
        chk("R6 keeps counting", cnt_q, 16'd32);
        wr_cnt(16'hFFFF);
        cyc();
        chk("R6 wraps to 0", cnt_q, 16'd0);
        clr_on_top = 1'b0;
        tick = 1'b0;
    endtask

    task automatic t_force();
        tick = 1'b0;
        out_mode = 2'b01; force_cmp = 1'b1; cyc(); force_cmp = 1'b0;
        chk("R7 force toggle", {15'b0, oc_state}, 16'h1);
        chk("R7 force no flag", {15'b0, match_flag}, 16'h0);
        chk("R7 force keeps cnt", cnt_q, 16'd0);
        out_mode = 2'b10; force_cmp = 1'b1; cyc(); force_cmp = 1'b0;
        chk("R7 force clear", {15'b0, oc_state}, 16'h0);
        out_mode = 2'b11; force_cmp = 1'b1; cyc(); force_cmp = 1'b0;
        chk("R7 force set", {15'b0, oc_state}, 16'h1);
        clr_on_top = 1'b1; out_mode = 2'b10; cyc(); cyc();
        chk("R8 oc holds over mode change", {15'b0, oc_state}, 16'h1);
        clr_on_top = 1'b0;
    endtask

    task automatic t_pin();
        port_bit = 1'b0; ddr_bit = 1'b1;
        out_mode = 2'b00; #1;
        chk("R9 port source", {15'b0, pin_out}, 16'h0);
        out_mode = 2'b11; #1;
        chk("R9 compare source", {15'b0, pin_out}, 16'h1);
        out_mode = 2'b00; port_bit = 1'b1; #1;
        chk("R9 back to port", {15'b0, pin_out}, 16'h1);
        chk("R10 output dir", {15'b0, pin_oe}, 16'h1);
        ddr_bit = 1'b0; #1;
        chk("R10 input dir", {15'b0, pin_oe}, 16'h0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; cnt_wr_en = 1'b0; cnt_wr_data = '0;
        cmp_val = 16'hFFF0; top_val = 16'hFFFF; clr_on_top = 1'b0;
        out_mode = 2'b00; force_cmp = 1'b0; port_bit = 1'b0; ddr_bit = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_match();
        t_block();
        t_top();
        t_force();
        t_pin();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule